// File: doc/BRIEF.md
# Serial Word-Addressed Register Loader

This block is the programming port of a frequency synthesizer control path. A host drives three wires: a serial clock, a serial data line and a load strobe. On every rising edge of the serial clock one data bit enters a 24-bit shift register. The first bit sent becomes bit 0 of the word and the last bit sent becomes bit 23. When the load strobe rises, the block decodes the most significant bits of the assembled word and copies the whole word into one of four 24-bit control registers. Because the address sits at the top of the word, it is the last part to arrive.

The address has a variable length. Two top bits are enough to pick the first three registers. The fourth register needs a third bit, and the one remaining code is rejected. A word is committed only if exactly 24 serial clock edges were counted since the previous strobe. This guards against a glitch or a truncated transfer. The low 22 bits of the first register form the fractional ratio field, which feeds a separate modulator.

The three serial wires are asynchronous to the block clock. They are oversampled through two-flop synchronizers, and their edges are detected in the block clock domain. Each register write produces a single-cycle update pulse, so downstream logic can reload its own state.

Top module: `ser_word_loader`

## Requirements
- R1: After reset the register outputs are A = 24'h035BA7 (fractional field 0000110101101110100111), B = 24'h400000, C = 24'h800000, D = 24'hC00000, and upd_o is 0.
- R2: Serial data is sampled on each rising edge of ser_clk. The first bit sent lands in bit 0 of the committed word and the 24th bit sent lands in bit 23.
- R3: On a commit, word bits 23:22 of 00 write register A, 01 write register B and 10 write register C. Bit 21 plays no part in selecting these three, is stored as data, and register A's bits 23:22 are always 00.
- R4: On a commit, word bits 23:21 of 110 write register D.
- R5: A word whose bits 23:21 are 111 changes no register and produces no update pulse.
- R6: A rising edge of ser_ld commits the word only if exactly 24 rising ser_clk edges were seen since the previous ser_ld rise (or since reset). Any other count, fewer or more, discards the word. Every ser_ld rise restarts the count.
- R7: upd_o bit 0/1/2/3 (for A/B/C/D) is high for exactly one clk cycle, and only in the first cycle in which that register shows its new value. A register output never changes without its pulse.
- R8: frac_o always equals register A bits 21:0.
- R9: A committed register output changes on the third rising clk edge after ser_ld goes high, when that input is set up ahead of the first of those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, bit 0 first |
| ser_ld | input | 1 | Load strobe, rising edge commits the word |
| reg_a_o | output | 24 | Register A contents |
| reg_b_o | output | 24 | Register B contents |
| reg_c_o | output | 24 | Register C contents |
| reg_d_o | output | 24 | Register D contents |
| frac_o | output | 22 | Fractional ratio field (register A bits 21:0) |
| upd_o | output | 4 | One-cycle write pulses, bit 0 = A to bit 3 = D |

## Verification
The embedded assertions check the following on every cycle:
- at most one update pulse is active, and no pulse lasts two cycles;
- register A changes only together with its pulse;
- any write was preceded by a bit count of exactly 24;
- a write to D always carries the 110 address;
- the edge counter clears after each strobe.

Only the bench scenarios can show the following:
- that bit order lands LSB first;
- that bit 21 is ignored for the A/B/C choice;
- that the 111 code, 23-bit words and 25-bit words leave every register untouched;
- that a committed value appears on exactly the third clock edge after the strobe.

The bench's cycle-accurate model compares all outputs on every cycle to catch the rest.

// File: rtl/ser_ld_pkg.sv
package ser_ld_pkg;

    localparam int WORD_W   = 24;
    localparam int NUM_REGS = 4;
    localparam int FRAC_W   = WORD_W - 2;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int SEL_W    = $clog2(NUM_REGS);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2,
        SEL_D = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } addr_dec_t;

    // Variable-length address: two top bits pick A/B/C, a third bit qualifies D.
    function automatic addr_dec_t decode_addr(input logic [2:0] top);
        addr_dec_t d;
        d.valid = 1'b1;
        unique case (top[2:1])
            2'b00:   d.sel = SEL_A;
            2'b01:   d.sel = SEL_B;
            2'b10:   d.sel = SEL_C;
            default: begin
                d.sel   = SEL_D;
                d.valid = ~top[0];
            end
        endcase
        return d;
    endfunction

    // Power-up contents of each control register.
    function automatic word_t reset_word(input int idx);
        word_t w;
        case (idx)
            0:       w = 24'h035BA7;
            1:       w = 24'h400000;
            2:       w = 24'h800000;
            default: w = 24'hC00000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/sld_sync_edge.sv
module sld_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/sld_shift_cnt.sv
module sld_shift_cnt
    import ser_ld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             clear_i,
    output word_t            word_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    word_t            sreg_q;
    logic [CNT_W-1:0] cnt_q;

    // Right shift: the oldest bit walks down to bit 0 after WORD_W shifts.
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else if (shift_i) begin
            sreg_q <= {bit_i, sreg_q[WORD_W-1:1]};
        end
    end

    // Saturating edge counter so an overlong burst never aliases to a full word.
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (shift_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign word_o = sreg_q;
    assign cnt_o  = cnt_q;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_o == '0)); // R6

    AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_MAX && !clear_i) |=> (cnt_o == CNT_MAX)); // R6

endmodule

// File: rtl/sld_addr_dec.sv
module sld_addr_dec
    import ser_ld_pkg::*;
(
    input  word_t               word_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                load_i,
    output logic [NUM_REGS-1:0] wr_en_o,
    output word_t               wr_data_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    addr_dec_t dec;
    logic      commit;

    always_comb begin
        dec     = decode_addr(word_i[WORD_W-1 -: 3]);
        commit  = load_i && (cnt_i == FULL_CNT) && dec.valid;
        wr_en_o = '0;
        if (commit) begin
            wr_en_o[dec.sel] = 1'b1;
        end
    end

    assign wr_data_o = word_i;

endmodule

// File: rtl/sld_reg_bank.sv
module sld_reg_bank
    import ser_ld_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_REGS-1:0]             wr_en_i,
    input  word_t                           wr_data_i,
    output logic [NUM_REGS-1:0][WORD_W-1:0] regs_o,
    output logic [NUM_REGS-1:0]             upd_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam word_t INIT = reset_word(g);
        word_t val_q;
        logic  upd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= INIT;
                upd_q <= 1'b0;
            end else begin
                upd_q <= wr_en_i[g];
                if (wr_en_i[g]) begin
                    val_q <= wr_data_i;
                end
            end
        end

        assign regs_o[g] = val_q;
        assign upd_o[g]  = upd_q;
    end

    AST_D_ADDR: assert property (@(posedge clk) disable iff (rst)
        upd_o[3] |-> (regs_o[3][WORD_W-1 -: 3] == 3'b110)); // R4

endmodule

// File: rtl/ser_word_loader.sv
module ser_word_loader
    import ser_ld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    output logic [WORD_W-1:0] reg_a_o,
    output logic [WORD_W-1:0] reg_b_o,
    output logic [WORD_W-1:0] reg_c_o,
    output logic [WORD_W-1:0] reg_d_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [3:0]        upd_o
);
    localparam int NUM_LINES = 3;
    localparam int L_CLK = 0;
    localparam int L_DAT = 1;
    localparam int L_LD  = 2;

    logic [NUM_LINES-1:0] raw_in;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] rise;

    assign raw_in = {ser_ld, ser_dat, ser_clk};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        sld_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw_in[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g])
        );
    end

    word_t                           sh_word;
    logic [CNT_W-1:0]                sh_cnt;
    logic [NUM_REGS-1:0]             wr_en;
    word_t                           wr_data;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    logic [NUM_REGS-1:0]             upd;

    sld_shift_cnt u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (rise[L_CLK]),
        .bit_i   (lvl[L_DAT]),
        .clear_i (rise[L_LD]),
        .word_o  (sh_word),
        .cnt_o   (sh_cnt)
    );

    sld_addr_dec u_dec (
        .word_i    (sh_word),
        .cnt_i     (sh_cnt),
        .load_i    (rise[L_LD]),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data)
    );

    sld_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .regs_o    (regs),
        .upd_o     (upd)
    );

    assign reg_a_o = regs[SEL_A];
    assign reg_b_o = regs[SEL_B];
    assign reg_c_o = regs[SEL_C];
    assign reg_d_o = regs[SEL_D];
    assign frac_o  = regs[SEL_A][FRAC_W-1:0];
    assign upd_o   = upd;

    AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o)); // R7

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|upd_o) |=> (upd_o == '0)); // R7

    AST_A_STABLE: assert property (@(posedge clk) disable iff (rst)
        !upd_o[0] |-> $stable(reg_a_o)); // R7

    AST_WRITE_FULL_CNT: assert property (@(posedge clk) disable iff (rst)
        (|upd_o) |-> ($past(sh_cnt) == CNT_W'(WORD_W))); // R6

    AST_A_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_a_o[WORD_W-1 -: 2] == 2'b00); // R3

endmodule

// File: tb/ser_word_loader_tb.sv
`timescale 1ns/1ps
module ser_word_loader_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_ld  = 1'b0;
    logic [23:0] reg_a_o, reg_b_o, reg_c_o, reg_d_o;
    logic [21:0] frac_o;
    logic [3:0]  upd_o;

    always #2.5 clk = ~clk;

    ser_word_loader u_dut (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_ld  (ser_ld),
        .reg_a_o (reg_a_o),
        .reg_b_o (reg_b_o),
        .reg_c_o (reg_c_o),
        .reg_d_o (reg_d_o),
        .frac_o  (frac_o),
        .upd_o   (upd_o)
    );

    int tests = 0;
    int fails = 0;

    // Behavioural reference model.
    logic [23:0] m_reg [4] = '{24'h035BA7, 24'h400000, 24'h800000, 24'hC00000};
    logic [3:0]  m_upd = '0;
    bit          sent_q [$];
    int          pend_cd  = 0;
    int          pend_idx = -1;
    logic [23:0] pend_word = '0;

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            m_upd = '0;
            if (pend_cd > 0) begin
                pend_cd--;
                if (pend_cd == 0 && pend_idx >= 0) begin
                    m_reg[pend_idx] = pend_word;
                    m_upd[pend_idx] = 1'b1;
                end
            end
            chk("R3 model reg A", reg_a_o, m_reg[0]);
            chk("R3 model reg B", reg_b_o, m_reg[1]);
            chk("R3 model reg C", reg_c_o, m_reg[2]);
            chk("R4 model reg D", reg_d_o, m_reg[3]);
            chk("R8 model frac",  {2'b00, frac_o}, {2'b00, m_reg[0][21:0]});
            chk("R7 model upd",   {20'd0, upd_o}, {20'd0, m_upd});
        end
    end

    // Decide the model's outcome for a strobe issued now.
    task automatic model_load();
        logic [23:0] w;
        w = '0;
        pend_idx = -1;
        if (sent_q.size() == 24) begin
            foreach (sent_q[i]) w[i] = sent_q[i];
            if (w[23:22] != 2'b11)  pend_idx = int'(w[23:22]);
            else if (!w[21])        pend_idx = 3;
        end
        pend_word = w;
        pend_cd   = 3;
        sent_q.delete();
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk) ser_dat = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        sent_q.push_back(b);
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i % 32]);
    endtask

    task automatic strobe();
        repeat (2) @(negedge clk);
        ser_ld = 1'b1;
        model_load();
        repeat (2) @(negedge clk);
        ser_ld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_word(input logic [23:0] w);
        send_bits({8'd0, w}, 24);
        strobe();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        chk("R1 reset reg A", reg_a_o, 24'h035BA7);
        chk("R1 reset reg B", reg_b_o, 24'h400000);
        chk("R1 reset reg C", reg_c_o, 24'h800000);
        chk("R1 reset reg D", reg_d_o, 24'hC00000);
        chk("R1 reset upd",   {20'd0, upd_o}, 24'd0);

        // R9: latency of a commit, first write of B (old value is its reset default).
        send_bits(32'h004C0FFE, 24);
        repeat (2) @(negedge clk);
        ser_ld = 1'b1;
        model_load();
        @(posedge clk); #2;
        chk("R9 edge1 reg B unchanged", reg_b_o, 24'h400000);
        @(posedge clk); #2;
        chk("R9 edge2 reg B unchanged", reg_b_o, 24'h400000);
        @(posedge clk); #2;
        chk("R9 edge3 reg B updated", reg_b_o, 24'h4C0FFE);
        chk("R7 pulse on B", {20'd0, upd_o}, 24'h000002);
        @(posedge clk); #2;
        chk("R7 pulse gone", {20'd0, upd_o}, 24'd0);
        @(negedge clk) ser_ld = 1'b0;
        repeat (4) @(negedge clk);

        // R2: LSB-first assembly into register A.
        load_word(24'h15A5A5);
        chk("R2 reg A", reg_a_o, 24'h15A5A5);
        chk("R8 frac", {2'b00, frac_o}, 24'h15A5A5);

        // R3: bit 21 set but B still selected.
        load_word(24'h6ABCDE);
        chk("R3 reg B bit21", reg_b_o, 24'h6ABCDE);
        load_word(24'h9F0F0F);
        chk("R3 reg C", reg_c_o, 24'h9F0F0F);
        load_word(24'hB12345);
        chk("R3 reg C bit21", reg_c_o, 24'hB12345);

        // R4: D with 110.
        load_word(24'hC54321);
        chk("R4 reg D", reg_d_o, 24'hC54321);

        // R5: 111 ignored.
        load_word(24'hE55555);
        chk("R5 reg A kept", reg_a_o, 24'h15A5A5);
        chk("R5 reg B kept", reg_b_o, 24'h6ABCDE);
        chk("R5 reg C kept", reg_c_o, 24'hB12345);
        chk("R5 reg D kept", reg_d_o, 24'hC54321);

        // R6: short and long words discarded, then a proper word commits.
        send_bits(32'h000AAAAA, 23);
        strobe();
        chk("R6 short word reg A", reg_a_o, 24'h15A5A5);
        send_bits(32'h00155555, 25);
        strobe();
        chk("R6 long word reg A", reg_a_o, 24'h15A5A5);
        send_bits(32'h00FFFFFF, 40);
        strobe();
        chk("R6 overlong reg D", reg_d_o, 24'hC54321);
        load_word(24'h0F00F1);
        chk("R6 recount reg A", reg_a_o, 24'h0F00F1);
        chk("R8 frac after recount", {2'b00, frac_o}, 24'h0F00F1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule